// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block picks the smaller or the larger of two IEEE-754 binary values and registers the choice, together with a six-bit exception flag word, on the next clock edge. One input selects single precision (32-bit operands in the low half of each 64-bit input) or double precision (full 64 bits). A second input selects minimum or maximum.

NaN handling departs from the plain IEEE minNum rule. If only one operand is a NaN, the other operand is the result, whether the NaN is quiet or signalling. If both operands are NaN, the result is the all-ones pattern of the selected width. A signalling NaN on either input raises the invalid flag. A quiet NaN raises nothing. The flag word uses the bit layout of a status register, but the only bit this unit can ever set is invalid.

Top module: `fp_minmax_unit`

## Requirements
- R1: Outputs are registered. The result and flags for the inputs present at a rising clock edge appear after that edge. While rst_ni is low at an edge, result_o and flags_o are cleared to zero.
- R2: For two non-NaN operands, is_max_i=0 returns the smaller value and is_max_i=1 returns the larger value. Values are ordered by sign and then by magnitude, in both precisions (is_double_i=1 selects 64-bit).
- R3: Signed zeros are ordered with -0 below +0. The minimum of -0 and +0 is -0 and the maximum is +0.
- R4: Infinities order normally: +inf is above every other non-NaN value and -inf is below every other non-NaN value.
- R5: When exactly one operand is a NaN, the result is the other operand, for both min and max.
- R6: When both operands are NaN, the result is 0xFFFFFFFF in single mode and 0xFFFFFFFFFFFFFFFF in double mode.
- R7: flags_o bit 1 (invalid) is set when at least one operand is a signalling NaN. It is clear when no operand is a signalling NaN, including when an operand is a quiet NaN.
- R8: flags_o bits 0, 2 (divide-by-zero), 3 (overflow), 4 (underflow) and 5 (inexact) are always zero.
- R9: In single mode, bits 63:32 of both inputs are ignored and bits 63:32 of result_o are zero.
- R10: A NaN has an all-ones exponent and a non-zero fraction. It is quiet when the top fraction bit is 1 (bit 22 in single, bit 51 in double) and signalling when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| a_i | input | 64 | First operand (single uses bits 31:0) |
| b_i | input | 64 | Second operand (single uses bits 31:0) |
| is_max_i | input | 1 | 1 selects maximum, 0 selects minimum |
| is_double_i | input | 1 | 1 selects double precision, 0 selects single |
| result_o | output | 64 | Registered selected value |
| flags_o | output | 6 | Registered exception flags (bit 1 invalid) |

## Verification
Random operand pairs are drawn from a class mix: random bits, signed zeros, infinities, quiet NaNs and signalling NaNs with random payloads, and same-sign values that differ only in low bits. This mix separates a sign-only compare from a magnitude compare, and a correct negative-magnitude inversion from a missing one. Pairs in which one side is a NaN tell "return the other operand" apart from NaN propagation. Quiet-against-signalling pairs tell the two NaN kinds apart through the invalid flag. Single-mode vectors carry random garbage in the upper input halves, which exposes any leak of those bits into the compare or into the result.

// File: rtl/fpmm_pkg.sv
// Package: shared widths, flag positions and the operand descriptor type
// used by the min/max unit. Assumes IEEE-754 binary32/binary64 layouts.
package fpmm_pkg;
    localparam int DBL_W    = 64;
    localparam int SGL_W    = 32;
    localparam int DBL_EXP  = 11;
    localparam int SGL_EXP  = 8;
    localparam int DBL_FRAC = DBL_W - 1 - DBL_EXP;
    localparam int SGL_FRAC = SGL_W - 1 - SGL_EXP;
    localparam int MAG_W    = DBL_W - 1;
    localparam int FLAG_W   = 6;
    localparam int FLG_INV  = 1;

    // Per-operand classification produced by the classifier.
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;
endpackage

// File: rtl/fpmm_classify.sv
// Module: fpmm_classify
// Splits one operand into sign, zero-extended magnitude and NaN kind for
// the selected precision. Assumes single operands sit in bits 31:0; the
// upper half is ignored in single mode.
module fpmm_classify
    import fpmm_pkg::*;
(
    input  logic [DBL_W-1:0] op_i,
    input  logic             is_double_i,
    output opnd_info_t       info_o
);
    logic [DBL_EXP-1:0]  d_exp;
    logic [DBL_FRAC-1:0] d_frac;
    logic [SGL_EXP-1:0]  s_exp;
    logic [SGL_FRAC-1:0] s_frac;

    assign d_exp  = op_i[DBL_W-2 -: DBL_EXP];
    assign d_frac = op_i[DBL_FRAC-1:0];
    assign s_exp  = op_i[SGL_W-2 -: SGL_EXP];
    assign s_frac = op_i[SGL_FRAC-1:0];

    // Pick the field view of the active precision and classify NaNs.
    always_comb begin
        if (is_double_i) begin
            info_o.sign    = op_i[DBL_W-1];
            info_o.mag     = op_i[MAG_W-1:0];
            info_o.is_nan  = (&d_exp) && (|d_frac);
            info_o.is_snan = info_o.is_nan && !d_frac[DBL_FRAC-1];
        end else begin
            info_o.sign    = op_i[SGL_W-1];
            info_o.mag     = {{(MAG_W-SGL_W+1){1'b0}}, op_i[SGL_W-2:0]};
            info_o.is_nan  = (&s_exp) && (|s_frac);
            info_o.is_snan = info_o.is_nan && !s_frac[SGL_FRAC-1];
        end
    end
endmodule

// File: rtl/fpmm_order.sv
// Module: fpmm_order
// Decides whether operand A is strictly below operand B for non-NaN
// values. Sign first, then magnitude (inverted for negatives). -0 sits
// below +0. NaN inputs give a don't-care answer; the caller overrides it.
module fpmm_order
    import fpmm_pkg::*;
(
    input  opnd_info_t a_i,
    input  opnd_info_t b_i,
    output logic       a_below_o
);
    logic mag_lt;
    logic mag_gt;

    assign mag_lt = a_i.mag < b_i.mag;
    assign mag_gt = b_i.mag < a_i.mag;

    // Sign-then-magnitude ordering.
    always_comb begin
        if (a_i.sign != b_i.sign) a_below_o = a_i.sign;
        else if (a_i.sign)        a_below_o = mag_gt;
        else                      a_below_o = mag_lt;
    end
endmodule

// File: rtl/fp_minmax_unit.sv
// Module: fp_minmax_unit (top)
// Registered min/max of two IEEE-754 values in single or double precision.
// A lone NaN yields the other operand, two NaNs yield all ones, and any
// signalling NaN raises the invalid flag (bit 1). Assumes a synchronous
// active-low reset. Single-mode results are zero-extended to 64 bits.
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DBL_W-1:0]  a_i,
    input  logic [DBL_W-1:0]  b_i,
    input  logic              is_max_i,
    input  logic              is_double_i,
    output logic [DBL_W-1:0]  result_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [DBL_W-1:0] ops   [2];
    opnd_info_t       infos [2];
    logic [DBL_W-1:0] a_eff, b_eff, pick, next_res;
    logic             a_below, take_a;
    logic [FLAG_W-1:0] next_flags;

    assign ops[0] = a_i;
    assign ops[1] = b_i;

    // One classifier per operand.
    for (genvar k = 0; k < 2; k++) begin : g_cls
        fpmm_classify u_cls (
            .op_i        (ops[k]),
            .is_double_i (is_double_i),
            .info_o      (infos[k])
        );
    end

    fpmm_order u_ord (
        .a_i       (infos[0]),
        .b_i       (infos[1]),
        .a_below_o (a_below)
    );

    // Operands trimmed to the active width.
    assign a_eff = is_double_i ? a_i : {{(DBL_W-SGL_W){1'b0}}, a_i[SGL_W-1:0]};
    assign b_eff = is_double_i ? b_i : {{(DBL_W-SGL_W){1'b0}}, b_i[SGL_W-1:0]};

    // Normal selection: min keeps the lower value, max the higher one.
    assign take_a = is_max_i ? !a_below : a_below;
    assign pick   = take_a ? a_eff : b_eff;

    // NaN overrides on top of the ordered pick.
    always_comb begin
        if (infos[0].is_nan && infos[1].is_nan)
            next_res = is_double_i ? {DBL_W{1'b1}}
                                   : {{(DBL_W-SGL_W){1'b0}}, {SGL_W{1'b1}}};
        else if (infos[0].is_nan) next_res = b_eff;
        else if (infos[1].is_nan) next_res = a_eff;
        else                      next_res = pick;
    end

    // Flag word: only the invalid position can be set.
    always_comb begin
        next_flags          = '0;
        next_flags[FLG_INV] = infos[0].is_snan || infos[1].is_snan;
    end

    // Output registers with synchronous clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            result_o <= '0;
            flags_o  <= '0;
        end else begin
            result_o <= next_res;
            flags_o  <= next_flags;
        end
    end
endmodule

// File: rtl/fpmm_checker.sv
// Module: fpmm_checker
// Temporal properties of fp_minmax_unit, attached through bind. Uses its
// own NaN decode of the inputs, separate from the design's classifier.
module fpmm_checker
    import fpmm_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DBL_W-1:0]  a_i,
    input logic [DBL_W-1:0]  b_i,
    input logic              is_max_i,
    input logic              is_double_i,
    input logic [DBL_W-1:0]  result_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic live_q;
    logic nan_a, nan_b;

    function automatic logic nan_of(input logic [DBL_W-1:0] v, input logic dbl);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    assign nan_a = nan_of(a_i, is_double_i);
    assign nan_b = nan_of(b_i, is_double_i);

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    a_r8_no_other_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q |-> (flags_o[5:2] == 4'd0 && flags_o[0] == 1'b0));

    a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && !$past(is_double_i)) |-> (result_o[63:32] == 32'd0));

    a_r6_both_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(nan_a && nan_b)) |->
        (result_o == ($past(is_double_i) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF)));

    a_r5_other_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(nan_a && !nan_b && is_double_i)) |-> (result_o == $past(b_i)));

    a_r7_no_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(!nan_a && !nan_b)) |-> !flags_o[1]);
endmodule

bind fp_minmax_unit fpmm_checker u_fpmm_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_i         (a_i),
    .b_i         (b_i),
    .is_max_i    (is_max_i),
    .is_double_i (is_double_i),
    .result_o    (result_o),
    .flags_o     (flags_o)
);

// File: tb/test_fp_minmax_unit.sv
module test_fp_minmax_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        is_max_i = 1'b0, is_double_i = 1'b0;
    logic [63:0] result_o;
    logic [5:0]  flags_o;
    int vectors = 0, fails = 0;
    bit done = 0;

    always #10 clk_i = ~clk_i;

    fp_minmax_unit i_fp_minmax_unit (
        .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
        .is_max_i(is_max_i), .is_double_i(is_double_i),
        .result_o(result_o), .flags_o(flags_o));

    // Order key: monotone unsigned mapping of the sign-magnitude value.
    function automatic logic [63:0] okey(input logic [63:0] v, input bit dbl);
        logic [63:0] x = dbl ? v : {32'd0, v[31:0]};
        logic s = dbl ? x[63] : x[31];
        logic [63:0] m = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        logic [63:0] sb = dbl ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
        return s ? (~x & m) : (x | sb);
    endfunction

    function automatic bit isnan(input logic [63:0] v, input bit dbl);
        return dbl ? (v[62:52] == 11'h7FF && v[51:0] != 0) : (v[30:23] == 8'hFF && v[22:0] != 0);
    endfunction

    function automatic bit issnan(input logic [63:0] v, input bit dbl);
        return isnan(v, dbl) && !(dbl ? v[51] : v[22]);
    endfunction

    function automatic logic [69:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input bit mx, input bit dbl);
        logic [63:0] ae = dbl ? a : {32'd0, a[31:0]};
        logic [63:0] be = dbl ? b : {32'd0, b[31:0]};
        logic [63:0] r;
        logic [5:0]  f = '0;
        bit na = isnan(a, dbl), nb = isnan(b, dbl);
        if (na && nb)  r = dbl ? '1 : 64'h0000_0000_FFFF_FFFF;
        else if (na)   r = be;
        else if (nb)   r = ae;
        else if (mx)   r = (okey(b, dbl) > okey(a, dbl)) ? be : ae;
        else           r = (okey(b, dbl) < okey(a, dbl)) ? be : ae;
        f[1] = issnan(a, dbl) || issnan(b, dbl);
        return {f, r};
    endfunction

    function automatic logic [63:0] gen(input bit dbl);
        logic [63:0] v = {$urandom, $urandom};
        int c = $urandom_range(0, 7);
        logic s = v[0];
        if (dbl) begin
            case (c)
                1: v = {s, 63'd0};
                2: v = {s, 11'h7FF, 52'd0};
                3: v = {s, 11'h7FF, 1'b1, v[50:0]};
                4: v = {s, 11'h7FF, 1'b0, v[50:1], 1'b1};
                5: v = {s, 11'h400, 44'd0, v[7:0]};
                default: ;
            endcase
        end else begin
            case (c)
                1: v[31:0] = {s, 31'd0};
                2: v[31:0] = {s, 8'hFF, 23'd0};
                3: v[31:0] = {s, 8'hFF, 1'b1, v[21:0]};
                4: v[31:0] = {s, 8'hFF, 1'b0, v[21:1], 1'b1};
                5: v[31:0] = {s, 8'h80, 15'd0, v[7:0]};
                default: ;
            endcase
        end
        return v;
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input bit mx, input bit dbl, input string req);
        logic [69:0] e = model(a, b, mx, dbl);
        @(negedge clk_i);
        a_i = a; b_i = b; is_max_i = mx; is_double_i = dbl;
        @(negedge clk_i);
        vectors++;
        if (result_o !== e[63:0] || flags_o !== e[69:64]) begin
            fails++;
            $display("FAIL %s: a=%h b=%h max=%0d dbl=%0d got %h/%b expected %h/%b",
                     req, a, b, mx, dbl, result_o, flags_o, e[63:0], e[69:64]);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        a_i = 64'h3FF0_0000_0000_0000; b_i = 64'h7FF0_0000_0000_0001; is_double_i = 1'b1;
        repeat (3) @(negedge clk_i);
        vectors++; // R1 reset state
        if (result_o !== 64'd0 || flags_o !== 6'd0) begin
            fails++;
            $display("FAIL R1: got %h/%b expected 0/0", result_o, flags_o);
        end
        rst_ni = 1'b1;
        // R2 ordinary values
        apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 1, "R2");
        apply(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1, 1, "R2");
        apply(64'h0000_0000_3F80_0000, 64'h0000_0000_BF80_0000, 0, 0, "R2");
        // R3 signed zeros
        apply(64'h0, 64'h8000_0000_0000_0000, 0, 1, "R3");
        apply(64'h8000_0000_0000_0000, 64'h0, 1, 1, "R3");
        apply(64'h0, 64'h8000_0000, 0, 0, "R3");
        // R4 infinities
        apply(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 1, 1, "R4");
        apply(64'hFF80_0000, 64'hFF7F_FFFF, 0, 0, "R4");
        // R5 / R7 / R10 lone NaN, quiet and signalling
        apply(64'h7FF8_0000_0000_0000, 64'h3F80_0000_0000_0000, 0, 1, "R5");
        apply(64'h7FF7_0000_0000_0000, 64'h3F80_0000_0000_0000, 1, 1, "R7");
        apply(64'h3F80_0000, 64'h7FC0_0000, 1, 0, "R5");
        apply(64'h3F80_0000, 64'h7F80_0001, 0, 0, "R10");
        // R6 two NaNs
        apply(64'h7FF7_0000_0000_0000, 64'h7FF7_0000_0000_0000, 0, 1, "R6");
        apply(64'h7FC0_0000, 64'h7FC0_0000, 1, 0, "R6");
        // R9 garbage in upper halves
        apply(64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 1, 0, "R9");
        // R8 and everything else under random mixes
        for (int i = 0; i < 3000; i++) begin
            bit d = $urandom_range(0, 1);
            apply(gen(d), gen(d), $urandom_range(0, 1), d, "R8");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule